// File: doc/BRIEF.md
# Backtrack Trail Unwinder

When a goal fails, every variable binding made since the current choice point was created has to be taken back. The trail is the stack that records the address of each such binding. This block receives two values: the trail top recorded in the choice point (the floor) and the live trail top. It walks the trail downward from the live top to the floor. For each trail cell it reads the stored address, then writes an unbound-variable word to that address. An unbound variable is a reference-tagged word whose pointer field holds its own address.

A single memory port carries both the trail reads and the variable writes. The port uses a request/acknowledge handshake and accepts any number of wait cycles. A start pulse begins a walk and a one-cycle done pulse ends it. At done, the trail-top output equals the floor, so the caller can adopt it as the new trail pointer. Restoring the other choice-point registers is left to the caller.

Top module: `trail_unwind`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low and `tr_out` is zero.
- R2: If `start` is accepted with `cur_tr` less than or equal to `saved_tr`, `done` rises in the next cycle and no memory request is issued.
- R3: Trail reads go to addresses `cur_tr-1`, `cur_tr-2`, down to `saved_tr`, in that order. No read goes below `saved_tr`.
- R4: Each trail read is followed by exactly one write to the address held in the low `AW` bits of the word that was read. The upper bits of the trail word are ignored. The written word has the reference tag (`REF_TAG`, default 2'b00) in its top `TAG_W` bits, zeros in the bits between, and the target address in its low `AW` bits.
- R5: A walk performs exactly `cur_tr - saved_tr` reads and the same number of writes. Trail cells are never written.
- R6: While `done` is high, `tr_out` equals the `saved_tr` value that was captured when the walk started.
- R7: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values into the next cycle. Each transfer completes on the cycle in which `mem_ack` is high, whatever the number of wait cycles before it.
- R8: `start` is ignored while `busy` is high. The walk in progress, and its result, are unaffected.
- R9: An acknowledged read is followed in the next cycle by a write request. Requests are only issued while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| saved_tr | input | AW | Trail top saved in the choice point (floor) |
| cur_tr | input | AW | Current trail top (next free cell) |
| busy | output | 1 | Walk in progress, including the done cycle |
| done | output | 1 | One-cycle pulse at the end of a walk |
| tr_out | output | AW | Trail top being unwound; equals floor at done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write to variable, 0 = read of trail cell |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Unbound-variable word to write |
| mem_rdata | input | DW | Read data, valid when `mem_ack` is high on a read |
| mem_ack | input | 1 | Transfer complete |

## Verification
The sweep covers three cases. First, trail ranges of length zero through five at several floors. A design with an off-by-one in its loop would either leave the bottom entry bound or read the cell below the floor. Second, an empty range and an inverted range (current below saved). A wrong design would issue a stray read, or report a top that is not the floor. Third, memory latencies of zero to two wait cycles, to catch a design that drops or changes a request before acknowledge. Trail words carry nonzero upper bits, so a design that copies the whole word as the target, or writes anything other than a self-pointer, lands on the wrong address or writes the wrong value. A start pulse during a walk checks that a design which reloads its pointers mid-walk would visibly corrupt the result.

// File: rtl/tu_pkg.sv
package tu_pkg;
  typedef enum logic [1:0] {
    TU_IDLE  = 2'd0,
    TU_READ  = 2'd1,
    TU_WRITE = 2'd2,
    TU_DONE  = 2'd3
  } tu_state_e;
endpackage

// File: rtl/tu_ctrl.sv
module tu_ctrl
  import tu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic nonempty,
  input  logic at_floor,
  input  logic mem_ack,
  output logic load,
  output logic take_rd,
  output logic req,
  output logic we,
  output logic done,
  output logic busy
);
  tu_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      TU_IDLE:  if (start) state_d = nonempty ? TU_READ : TU_DONE;
      TU_READ:  if (mem_ack) state_d = TU_WRITE;
      TU_WRITE: if (mem_ack) state_d = at_floor ? TU_DONE : TU_READ;
      TU_DONE:  state_d = TU_IDLE;
      default:  state_d = TU_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TU_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    load    = (state_q == TU_IDLE) && start;
    take_rd = (state_q == TU_READ) && mem_ack;
    req     = (state_q == TU_READ) || (state_q == TU_WRITE);
    we      = (state_q == TU_WRITE);
    done    = (state_q == TU_DONE);
    busy    = (state_q != TU_IDLE);
  end
endmodule

// File: rtl/tu_ptr.sv
module tu_ptr #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          take_rd,
  input  logic [AW-1:0] saved_tr,
  input  logic [AW-1:0] cur_tr,
  input  logic [DW-1:0] rdata,
  output logic          nonempty,
  output logic          at_floor,
  output logic [AW-1:0] top,
  output logic [AW-1:0] tgt,
  output logic [AW-1:0] rd_addr
);
  logic [AW-1:0] top_q, top_d;
  logic [AW-1:0] floor_q, floor_d;
  logic [AW-1:0] tgt_q, tgt_d;
  logic          top_en, floor_en, tgt_en;

  assign nonempty = cur_tr > saved_tr;

  always_comb begin
    top_en   = load || take_rd;
    floor_en = load;
    tgt_en   = take_rd;
    top_d    = load ? (nonempty ? cur_tr : saved_tr) : top_q - AW'(1);
    floor_d  = saved_tr;
    tgt_d    = rdata[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q   <= '0;
      floor_q <= '0;
      tgt_q   <= '0;
    end else begin
      if (top_en)   top_q   <= top_d;
      if (floor_en) floor_q <= floor_d;
      if (tgt_en)   tgt_q   <= tgt_d;
    end
  end

  assign at_floor = (top_q == floor_q);
  assign top      = top_q;
  assign tgt      = tgt_q;
  assign rd_addr  = top_q - AW'(1);
endmodule

// File: rtl/tu_fmt.sv
module tu_fmt #(
  parameter int          AW      = 16,
  parameter int          DW      = 32,
  parameter int          TAG_W   = 2,
  parameter logic [TAG_W-1:0] REF_TAG = '0
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] word
);
  localparam int PAD_W = DW - TAG_W - AW;
  assign word = {REF_TAG, {PAD_W{1'b0}}, addr};
endmodule

// File: rtl/trail_unwind.sv
module trail_unwind #(
  parameter int          AW      = 16,
  parameter int          DW      = 32,
  parameter int          TAG_W   = 2,
  parameter logic [TAG_W-1:0] REF_TAG = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] saved_tr,
  input  logic [AW-1:0] cur_tr,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] tr_out,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack
);
  logic          load, take_rd, nonempty, at_floor;
  logic [AW-1:0] tgt, rd_addr;

  tu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .nonempty(nonempty),
    .at_floor(at_floor), .mem_ack(mem_ack), .load(load), .take_rd(take_rd),
    .req(mem_req), .we(mem_we), .done(done), .busy(busy)
  );

  tu_ptr #(.AW(AW), .DW(DW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(load), .take_rd(take_rd),
    .saved_tr(saved_tr), .cur_tr(cur_tr), .rdata(mem_rdata),
    .nonempty(nonempty), .at_floor(at_floor), .top(tr_out),
    .tgt(tgt), .rd_addr(rd_addr)
  );

  tu_fmt #(.AW(AW), .DW(DW), .TAG_W(TAG_W), .REF_TAG(REF_TAG)) u_fmt (
    .addr(tgt), .word(mem_wdata)
  );

  assign mem_addr = mem_we ? tgt : rd_addr;
endmodule

// File: rtl/tu_chk.sv
module tu_chk #(
  parameter int          AW      = 16,
  parameter int          DW      = 32,
  parameter int          TAG_W   = 2,
  parameter logic [TAG_W-1:0] REF_TAG = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] saved_tr,
  input logic [AW-1:0] cur_tr,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] tr_out,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_rdata,
  input logic          mem_ack
);
  logic [AW-1:0] sv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               sv_q <= '0;
    else if (start && !busy)  sv_q <= saved_tr;
  end

  a_r9_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  a_r2_done_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  a_r3_read_above_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr >= sv_q));

  a_r4_self_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata == {REF_TAG, {(DW-TAG_W-AW){1'b0}}, mem_addr}));

  a_r6_top_at_floor: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tr_out == sv_q));

  a_r7_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  a_r9_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_we) |=> (mem_req && mem_we));
endmodule

bind trail_unwind tu_chk #(.AW(AW), .DW(DW), .TAG_W(TAG_W), .REF_TAG(REF_TAG)) u_chk (.*);

// File: tb/trail_unwind_test.sv
module trail_unwind_test;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] saved_tr = '0;
  logic [AW-1:0] cur_tr = '0;
  logic          busy, done, mem_req, mem_we;
  logic [AW-1:0] tr_out, mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ack = 1'b0;

  trail_unwind #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .saved_tr(saved_tr), .cur_tr(cur_tr),
    .busy(busy), .done(done), .tr_out(tr_out), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model with programmable wait cycles
  logic [DW-1:0] mem [256];
  int            lat = 0;
  int            wcnt = 0;
  int            rd_cnt = 0;
  int            wr_cnt = 0;
  int            exp_top = 0;
  logic [AW-1:0] last_tgt = '0;

  always @(posedge clk) begin
    cyc++;
    if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          chk(mem_addr == last_tgt, "R4 write address", mem_addr, last_tgt);
          chk(mem_wdata == DW'(mem_addr), "R4 write data", mem_wdata, DW'(mem_addr));
          chk(mem_addr >= 8'd128, "R5 no trail write", mem_addr, 128);
          mem[mem_addr] <= mem_wdata;
          wr_cnt++;
        end else begin
          chk(int'(mem_addr) == exp_top - 1 - rd_cnt, "R3 read order", mem_addr, exp_top - 1 - rd_cnt);
          mem_rdata <= mem[mem_addr];
          last_tgt  = mem[mem_addr][AW-1:0];
          rd_cnt++;
        end
      end else begin
        wcnt++;
      end
    end
  end

  function automatic int tgt_of(input int sv, input int i);
    return 128 + ((sv + 3 * i) & 63);
  endfunction

  task automatic run_case(input int sv, input int cu, input int l, input bit poke);
    int n, waited;
    n = (cu > sv) ? cu - sv : 0;
    @(negedge clk);
    lat = l; rd_cnt = 0; wr_cnt = 0; exp_top = cu;
    for (int a = 128; a < 256; a++) mem[a] = 32'hC000_0000 | a;
    for (int i = 0; i < n; i++) mem[sv + i] = 32'h4055_AA00 | tgt_of(sv, i);
    saved_tr = AW'(sv); cur_tr = AW'(cu); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 1;
    while (!done && waited < 400) begin
      if (poke && waited == 3) begin
        chk(busy == 1'b1, "R8 busy mid-walk", busy, 1);
        saved_tr = 8'd1; cur_tr = 8'd60; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      waited++;
    end
    chk(done == 1'b1, "R6 done reached", done, 1);
    if (n == 0) begin
      chk(waited == 1, "R2 done next cycle", waited, 1);
      chk(rd_cnt == 0 && wr_cnt == 0, "R2 no access", rd_cnt + wr_cnt, 0);
    end
    chk(tr_out == AW'(sv), "R6 top equals floor", tr_out, sv);
    chk(rd_cnt == n, "R5 read count", rd_cnt, n);
    chk(wr_cnt == n, "R5 write count", wr_cnt, n);
    for (int i = 0; i < n; i++) begin
      chk(mem[tgt_of(sv, i)] == 32'(tgt_of(sv, i)), "R4 variable unbound", mem[tgt_of(sv, i)], tgt_of(sv, i));
      chk(mem[sv + i] == (32'h4055_AA00 | tgt_of(sv, i)), "R5 trail intact", mem[sv + i], 32'h4055_AA00 | tgt_of(sv, i));
    end
    @(negedge clk);
    chk(!done && !busy, "R9 back to idle", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && tr_out == 0, "R1 reset state",
        {busy, done, mem_req, tr_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R1 idle after release", {busy, mem_req}, 0);
    foreach (sweep_sv[k])
      for (int n = 0; n < 6; n++)
        for (int l = 0; l < 3; l++)
          run_case(sweep_sv[k], sweep_sv[k] + n, l, 1'b0);
    run_case(10, 7, 1, 1'b0);   // R2 inverted range
    run_case(20, 24, 2, 1'b1);  // R8 start while busy
    run_case(0, 1, 4, 1'b0);    // R7 long wait
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int sweep_sv [4] = '{0, 5, 40, 100};

  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule